// File: doc/BRIEF.md
# Pretrigger Ring Capture Controller

This block writes a stream of wide samples into a synchronous single-port memory that is used as a ring, while it waits for a trigger. Every sample is one memory word, and every channel in that word is captured in the same cycle. The controller can take one sample on each clock. This lets the memory fill at the full sample rate, with no gaps added by the controller.

Software picks a split between history and aftermath. It does this with a split value that counts the pre-trigger region in whole granules of 2^GRAN_LG samples. The rest of the ring is the post-trigger region. The split is latched by the arm pulse.

- **Before the trigger:** after arming, the controller ignores triggers until the pre-trigger region has been completely written.
- **On the trigger:** the trigger sample is written, and its address is held on a status output.
- **After the trigger:** exactly one post-trigger region of samples is written, counting the trigger sample. The controller then stops.
- **Reading back:** once stopped, the memory address follows a read-address input, so the host can read the ring. The host unrolls the ring from the latched trigger address.

**Sample stream rules:**
- The sample input is a valid/ready stream. `smp_ready_o` is high exactly while a capture is running.
- A sample transfers when valid and ready are both high and `arm_i` is low.
- There is no back-pressure inside a capture: ready never drops while the capture runs.
- Samples offered while ready is low are not stored.
- A trigger counts only when it arrives together with a transferred sample.

Top module: `cap_ring_ctrl`

## Requirements
- R1: After reset, `armed_o`, `triggered_o`, `done_o`, `smp_ready_o` and `mem_we_o` are all low.
- R2: A cycle with `arm_i` high writes nothing. The following cycle shows `armed_o`=1, `triggered_o`=0 and `done_o`=0, and the next stored sample goes to address 0.
- R3: While armed, a transferred sample drives `mem_we_o`=1 in the same cycle. In that cycle `mem_addr_o` is the write pointer and `mem_wdata_o` is the sample. The pointer then advances by one, modulo 2^ADDR_W.
- R4: With split value P, a trigger is ignored unless at least P·2^GRAN_LG samples have been stored since arming, not counting the sample it arrives with.
- R5: With P=0, a trigger on the very first sample after arming is accepted.
- R6: `trig_addr_o` gives the address of the accepted trigger sample. It and `triggered_o` hold until the next arm.
- R7: Counting the trigger sample, exactly (2^(ADDR_W−GRAN_LG) − P)·2^GRAN_LG samples are stored after the trigger. `done_o` then rises and `armed_o` falls in the following cycle.
- R8: While not armed, `mem_we_o` and `smp_ready_o` are low, and `mem_addr_o` equals `rd_addr_i`.
- R9: A trigger pulse in a cycle with no transferred sample has no effect.
- R10: Arming during a capture restarts it, with the pointer back at 0 and a fresh pre-trigger fill.
- R11: The split is sampled only on the arm pulse. Changing `split_i` during a capture has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start a capture; latches the split |
| split_i | input | ADDR_W-GRAN_LG | Pre-trigger granule count |
| smp_valid_i | input | 1 | Sample valid |
| smp_ready_o | output | 1 | Sample accepted when high |
| smp_data_i | input | DATA_W | Sample word, one bit per channel |
| trig_i | input | 1 | Trigger pulse from trigger unit |
| rd_addr_i | input | ADDR_W | Readback address |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| armed_o | output | 1 | Capture running |
| triggered_o | output | 1 | Trigger accepted |
| done_o | output | 1 | Capture finished |
| trig_addr_o | output | ADDR_W | Address of trigger sample |

## Verification
Each internal fault shows up at the ports within a cycle of the event it corrupts:

- **Write pointer:** a wrong pointer appears on `mem_addr_o` on the very next write.
- **Pre-trigger fill count:** a wrong count shows as `triggered_o` rising one cycle early or late relative to the trigger sample.
- **Post-trigger counter:** an error moves the rise of `done_o` away from the cycle after the last expected write. Extra writes then appear as `mem_we_o` pulses after `done_o` should be high.

A behavioural model in the bench predicts each of these ports every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_wptr.sv
module cap_wptr #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] wp
);
  logic [ADDR_W-1:0] wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wp_q <= '0;
    else if (clr) wp_q <= '0;
    else if (inc) wp_q <= wp_q + 1'b1;
  end

  assign wp = wp_q;
endmodule

// File: rtl/cap_fill.sv
module cap_fill #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] target,
  output logic             full
);
  logic [CNT_W-1:0] cnt_q;

  assign full = (cnt_q >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (inc && !full)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cap_post.sv
module cap_post #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] rem_q;

  assign last = (rem_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rem_q <= '0;
    else if (load)                    rem_q <= load_val;
    else if (dec && rem_q != '0)      rem_q <= rem_q - 1'b1;
  end

  AST_POST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (rem_q != '0)); // R7
endmodule

// File: rtl/cap_ring_ctrl.sv
module cap_ring_ctrl
  import cap_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 32,
  parameter int GRAN_LG = 13,
  localparam int SPLIT_W = ADDR_W - GRAN_LG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_i,
  input  logic [SPLIT_W-1:0] split_i,
  input  logic               smp_valid_i,
  output logic               smp_ready_o,
  input  logic [DATA_W-1:0]  smp_data_i,
  input  logic               trig_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic               mem_we_o,
  output logic               armed_o,
  output logic               triggered_o,
  output logic               done_o,
  output logic [ADDR_W-1:0]  trig_addr_o
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1) << ADDR_W;

  cap_state_e         st_q, st_d;
  logic [SPLIT_W-1:0] split_q;
  logic [ADDR_W-1:0]  taddr_q;
  logic [ADDR_W-1:0]  wp;
  logic [CNT_W-1:0]   pre_len, post_len;
  logic               running, accept, take_trig, fill_full, post_last;

  assign running   = (st_q == ST_PRE) || (st_q == ST_POST);
  assign accept    = running && smp_valid_i && !arm_i;
  assign pre_len   = CNT_W'(split_q) << GRAN_LG;
  assign post_len  = DEPTH_C - pre_len;
  assign take_trig = accept && (st_q == ST_PRE) && trig_i && fill_full;

  always_comb begin
    st_d = st_q;
    if (arm_i) st_d = ST_PRE;
    else begin
      case (st_q)
        ST_PRE:  if (take_trig) st_d = (post_len == CNT_W'(1)) ? ST_DONE : ST_POST;
        ST_POST: if (accept && post_last) st_d = ST_DONE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      split_q <= '0;
      taddr_q <= '0;
    end else begin
      st_q <= st_d;
      if (arm_i)     split_q <= split_i;
      if (take_trig) taddr_q <= wp;
    end
  end

  cap_wptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk(clk), .rst_n(rst_n), .clr(arm_i), .inc(accept), .wp(wp)
  );

  cap_fill #(.CNT_W(CNT_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(arm_i),
    .inc(accept && (st_q == ST_PRE)), .target(pre_len), .full(fill_full)
  );

  cap_post #(.CNT_W(CNT_W)) u_post (
    .clk(clk), .rst_n(rst_n), .load(take_trig), .load_val(post_len - CNT_W'(1)),
    .dec(accept && (st_q == ST_POST)), .last(post_last)
  );

  assign smp_ready_o = running;
  assign mem_we_o    = accept;
  assign mem_addr_o  = running ? wp : rd_addr_i;
  assign mem_wdata_o = smp_data_i;
  assign armed_o     = running;
  assign triggered_o = (st_q == ST_POST) || (st_q == ST_DONE);
  assign done_o      = (st_q == ST_DONE);
  assign trig_addr_o = taddr_q;

  AST_WE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> armed_o); // R8
  AST_ARM_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (armed_o && !triggered_o && !done_o)); // R2
  AST_TRIG_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(triggered_o) |-> $past(smp_valid_i && trig_i)); // R9
  AST_TRIG_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered_o && !arm_i) |=> $stable(trig_addr_o)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_we_o && !smp_ready_o)); // R7
endmodule

// File: tb/test_cap_ring_ctrl.sv
module test_cap_ring_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int GL = 4;
  localparam int SW = AW - GL;
  localparam int DEPTH = 1 << AW;
  localparam int GRAN = 1 << GL;
  localparam int NGRAN = 1 << SW;

  logic clk = 0, rst_n = 0;
  logic arm = 0, valid = 0, trig = 0;
  logic [SW-1:0] split = '0;
  logic [DW-1:0] data = '0;
  logic [AW-1:0] rd = '0;
  logic ready, we, armed, trgd, done;
  logic [AW-1:0] maddr, taddr;
  logic [DW-1:0] wdata;

  int tests = 0, fails = 0, wr_cnt = 0;
  int m_armed = 0, m_trg = 0, m_done = 0, m_wp = 0, m_pre = 0, m_post = 0;
  int m_split = 0, m_taddr = 0;

  always #10 clk = ~clk;

  cap_ring_ctrl #(.ADDR_W(AW), .DATA_W(DW), .GRAN_LG(GL)) i_cap_ring_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .split_i(split),
    .smp_valid_i(valid), .smp_ready_o(ready), .smp_data_i(data),
    .trig_i(trig), .rd_addr_i(rd), .mem_addr_o(maddr), .mem_wdata_o(wdata),
    .mem_we_o(we), .armed_o(armed), .triggered_o(trgd), .done_o(done),
    .trig_addr_o(taddr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare to model, then advance the model
  task automatic step(input logic a, input int s, input logic v, input logic t);
    logic e_we;
    int e_addr;
    arm = a; split = SW'(s); valid = v; trig = t; data = DW'($urandom);
    rd = AW'($urandom);
    #1;
    e_we = (m_armed != 0) && v && !a;
    e_addr = (m_armed != 0) ? m_wp : int'(rd);
    chk(ready == (m_armed != 0), "R8 ready", int'(ready), m_armed);
    chk(we == e_we, "R3 write enable", int'(we), int'(e_we));
    chk(int'(maddr) == e_addr, "R3/R8 address", int'(maddr), e_addr);
    if (e_we) chk(wdata == data, "R3 write data", int'(wdata), int'(data));
    chk(armed == (m_armed != 0), "R2/R7 armed", int'(armed), m_armed);
    chk(trgd == (m_trg != 0), "R6 triggered", int'(trgd), m_trg);
    chk(done == (m_done != 0), "R7 done", int'(done), m_done);
    if (m_trg != 0) chk(int'(taddr) == m_taddr, "R6 trigger address", int'(taddr), m_taddr);
    if (we) wr_cnt++;
    @(posedge clk);
    if (a) begin
      m_armed = 1; m_trg = 0; m_done = 0; m_wp = 0; m_pre = 0; m_post = 0;
      m_split = s; wr_cnt = 0;
    end else if (m_armed != 0 && v) begin
      if (m_trg == 0) begin
        if (t && m_pre >= m_split * GRAN) begin
          m_trg = 1; m_taddr = m_wp; m_post = 1;
        end else m_pre++;
      end else m_post++;
      if (m_trg != 0 && m_post == (NGRAN - m_split) * GRAN) begin
        m_done = 1; m_armed = 0;
      end
      m_wp = (m_wp + 1) % DEPTH;
    end
    @(negedge clk);
  endtask

  // offer samples; trigger on sample indices hit1/hit2, stray triggers on idle cycles
  task automatic stream(input int max_smp, input int hit1, input int hit2,
                        input int pct, input int s, input int stop_at);
    int idx = 0;
    while (idx < max_smp && m_done == 0) begin
      logic v;
      logic t;
      if (idx == stop_at) return;
      v = ($urandom % 100) < pct;
      t = v ? (idx == hit1 || idx == hit2) : (($urandom % 3) == 0);
      step(1'b0, s, v, t);
      if (v) idx++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: state during and right after reset
    chk(!armed && !trgd && !done && !ready && !we, "R1 reset outputs", int'(armed | trgd | done | we), 0);
    rst_n = 1;
    step(1'b0, 0, 1'b1, 1'b1);
    chk(!we && !armed, "R1 idle after reset", int'(we), 0);

    // R5: split 0, trigger on first sample accepted
    step(1'b1, 0, 1'b0, 1'b0);
    step(1'b0, 0, 1'b1, 1'b1);
    chk(trgd == 1'b1, "R5 immediate trigger", int'(trgd), 1);
    chk(taddr == '0, "R5 trigger address", int'(taddr), 0);
    stream(DEPTH + 10, -1, -1, 100, 0, -1);
    chk(done == 1'b1, "R7 done after full ring", int'(done), 1);
    chk(wr_cnt == DEPTH, "R7 write count split 0", wr_cnt, DEPTH);

    // R4, R9: split 3 -> 48 pre samples; early triggers ignored
    step(1'b1, 3, 1'b0, 1'b0);
    stream(48, 10, 47, 70, 3, -1);
    chk(trgd == 1'b0, "R4 early triggers ignored", int'(trgd), 0);
    stream(1, 0, -1, 70, 3, -1);
    chk(trgd == 1'b1 && taddr == AW'(48), "R4/R6 trigger at fill boundary", int'(taddr), 48);
    stream(DEPTH, -1, -1, 60, 3, -1);
    chk(done == 1'b1 && wr_cnt == DEPTH, "R7 write count split 3", wr_cnt, DEPTH);
    // R8: samples and triggers after done are dropped, readback address passes through
    for (int k = 0; k < 5; k++) step(1'b0, 5, 1'b1, 1'b1);
    chk(!we && int'(maddr) == int'(rd) && int'(taddr) == 48, "R8 stopped readback", int'(we), 0);

    // R10, R11: start split 15, re-arm mid capture with split 2, then change split input
    step(1'b1, 15, 1'b0, 1'b0);
    stream(DEPTH, -1, -1, 100, 0, 20);
    chk(armed && !trgd, "R10 capture running before restart", int'(trgd), 0);
    step(1'b1, 2, 1'b1, 1'b0);
    chk(maddr == '0 && armed, "R10 pointer restarted", int'(maddr), 0);
    stream(DEPTH * 3, 5, 300, 85, 15, -1);
    chk(trgd && taddr == AW'(300 % DEPTH), "R3/R11 wrapped trigger address", int'(taddr), 300 % DEPTH);
    chk(done && wr_cnt == 300 + (NGRAN - 2) * GRAN, "R7/R11 write count split 2", wr_cnt, 300 + (NGRAN - 2) * GRAN);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule